// File: doc/BRIEF.md
# Single-Clock FIFO with Show-Ahead Read and Coarse Fill Codes

This block is a first-in first-out buffer whose producer and consumer run on the same clock and reset. The producer offers a word with a `put` strobe. The word is taken only while `full` is low. The consumer sees the oldest stored word on `rdata` whenever `valid` is high. It pulses `got` to say that this word has been used, and the next word then moves up to the head. The capacity is set by a minimum-depth parameter. The built depth is that value rounded up to a power of two, and never less than two.

Each side also gets a coarse level code. The read side reports how much of the buffer is at least filled. The write side reports how much room is at least free. Both codes use steps of 1/2^bits of the depth and come combinationally from the difference of the two pointers. Each code is a lower bound: it never claims more words or more room than truly exist. `full` and `valid` therefore stay the signals that govern flow control. A code width of zero removes that code and leaves a single constant-zero bit on the port.

Two build options are available. One registers the full and empty status. The other adds an output register in front of the read port, which adds one word of capacity and one cycle of latency.

Top module: `sfifo_gv`

## Requirements
- R1: While reset is applied, and until the internal reset release completes, `valid` and `full` are 0, `rd_fill` is 0 and `wr_room` holds its all-ones code.
- R2: The capacity is 2^ceil(log2(DEPTH_MIN)), with a minimum of 2. With DEPTH_MIN=5 that is 8 words. `full` is 1 exactly when that many words are stored.
- R3: A `put` while `full` is 1 is dropped. The word never appears on the read port, and `full` stays 1 unless a word is consumed.
- R4: Words leave in the order they were accepted. While `valid` is 1, `rdata` shows the oldest word. With the output register off, an accepted word into an empty buffer is visible with `valid`=1 in the cycle after its clock edge.
- R5: A `got` while `valid` is 0 has no effect. The buffer stays empty, `rd_fill` stays 0, and a later word is still delivered.
- R6: A `put` and a `got` in the same cycle, while the buffer is neither empty nor full, leave the occupancy and both level codes unchanged.
- R7: With RD_LVL_BITS=B>0, `rd_fill` equals floor(count·2^B/capacity), saturated at 2^B−1. It never exceeds the true count in those steps.
- R8: With WR_LVL_BITS=B>0, `wr_room` equals floor(free·2^B/capacity), saturated at 2^B−1. It never exceeds the true free space in those steps.
- R9: While `valid` is 1 and `got` is 0, `valid` stays 1 and `rdata` is held at the next cycle.
- R10: A level width of 0 drives that port as a constant 1-bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| put | input | 1 | Offer `wdata` for storage |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | No room; `put` is ignored |
| wr_room | output | max(1,WR_LVL_BITS) | Coarse guaranteed free space |
| got | input | 1 | The head word has been consumed |
| rdata | output | DATA_W | Oldest stored word (show-ahead) |
| valid | output | 1 | `rdata` holds a word |
| rd_fill | output | max(1,RD_LVL_BITS) | Coarse guaranteed stored count |

## Verification
Every status output moves one clock edge after the `put` or `got` that causes it. The flags and the level codes both follow from pointers that are updated on that edge. The bench therefore applies each stimulus after a falling edge, lets exactly one rising edge pass, and compares `valid`, `rdata`, `full` and both level codes at the next falling edge. It compares them against a queue model that was updated once for that same edge. The all-ones room code during reset and the constant zero of a disabled code are checked with no edge needed. The hold checks under R9 look at the outputs on several successive falling edges while no `got` is given.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Pointer index width for a requested minimum depth; never below one bit.
  function automatic int unsigned addr_bits(input int unsigned min_depth);
    int unsigned b;
    b = $clog2(min_depth);
    if (b < 1) b = 1;
    return b;
  endfunction

  // Width of a level port: a disabled code keeps one placeholder bit.
  function automatic int unsigned code_width(input int unsigned bits);
    return (bits == 0) ? 1 : bits;
  endfunction

endpackage

// File: rtl/sfifo_ptr.sv
module sfifo_ptr #(
  parameter int unsigned AW       = 4,
  parameter bit          FLAG_REG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   occ,
  output logic          full,
  output logic          empty
);

  localparam logic [AW:0] DEPTH_C = {1'b1, {AW{1'b0}}};

  logic [AW:0] wr_q, wr_d;
  logic [AW:0] rd_q, rd_d;
  logic [AW:0] occ_d;

  // next-state
  always_comb begin
    wr_d  = wr_q + {{AW{1'b0}}, push};
    rd_d  = rd_q + {{AW{1'b0}}, pop};
    occ_d = wr_d - rd_d;
  end

  // pointer registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (push) begin
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (pop) begin
      rd_q <= rd_d;
    end
  end

  assign wr_addr = wr_q[AW-1:0];
  assign rd_addr = rd_q[AW-1:0];
  assign occ     = wr_q - rd_q;

  generate
    if (FLAG_REG) begin : g_flag_reg
      logic full_q, empty_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q  <= 1'b0;
          empty_q <= 1'b1;
        end else begin
          full_q  <= (occ_d == DEPTH_C);
          empty_q <= (occ_d == '0);
        end
      end
      assign full  = full_q;
      assign empty = empty_q;
    end else begin : g_flag_comb
      logic unused_occ_d;
      assign unused_occ_d = ^occ_d;
      assign full  = (occ == DEPTH_C);
      assign empty = (occ == '0);
    end
  endgenerate

endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 4,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  // asynchronous read gives the show-ahead head word
  assign rdata = cells[raddr];

endmodule

// File: rtl/sfifo_head.sv
module sfifo_head #(
  parameter int unsigned DATA_W  = 8,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_empty,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              got,
  output logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] dout
);

  generate
    if (OUT_REG) begin : g_stage
      logic              hv_q, hv_d;
      logic [DATA_W-1:0] hd_q;
      logic              load;

      always_comb begin
        load = !mem_empty && (!hv_q || got);
        hv_d = load || (hv_q && !got);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hv_q <= 1'b0;
        end else begin
          hv_q <= hv_d;
        end
      end

      always_ff @(posedge clk) begin
        if (load) begin
          hd_q <= mem_data;
        end
      end

      assign pop   = load;
      assign valid = hv_q;
      assign dout  = hd_q;
    end else begin : g_direct
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign pop   = got && !mem_empty;
      assign valid = !mem_empty;
      assign dout  = mem_data;
    end
  endgenerate

endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int unsigned AW   = 4,
  parameter int unsigned BITS = 2,
  localparam int unsigned OW  = (BITS == 0) ? 1 : BITS
) (
  input  logic [AW:0]   cnt,
  output logic [OW-1:0] code
);

  generate
    if (BITS == 0) begin : g_off
      logic unused_cnt;
      assign unused_cnt = ^cnt;
      assign code = '0;
    end else begin : g_on
      logic [AW+BITS:0] scaled;
      logic [BITS:0]    quot;
      logic             unused_lo;
      assign scaled    = {{BITS{1'b0}}, cnt} << BITS;
      assign quot      = scaled[AW+BITS:AW];
      assign unused_lo = ^scaled[AW-1:0];
      // only the exact-capacity value reaches 2^BITS; clamp it
      assign code      = quot[BITS] ? {BITS{1'b1}} : quot[BITS-1:0];
    end
  endgenerate

endmodule

// File: rtl/sfifo_gv.sv
module sfifo_gv #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DEPTH_MIN   = 16,
  parameter bit          FLAG_REG    = 1'b0,
  parameter bit          OUT_REG     = 1'b0,
  parameter int unsigned RD_LVL_BITS = 0,
  parameter int unsigned WR_LVL_BITS = 0,
  localparam int unsigned AW  = sfifo_pkg::addr_bits(DEPTH_MIN),
  localparam int unsigned RLW = sfifo_pkg::code_width(RD_LVL_BITS),
  localparam int unsigned WLW = sfifo_pkg::code_width(WR_LVL_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  output logic [WLW-1:0]    wr_room,
  input  logic              got,
  output logic [DATA_W-1:0] rdata,
  output logic              valid,
  output logic [RLW-1:0]    rd_fill
);

  localparam logic [AW:0] DEPTH_C = {1'b1, {AW{1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  logic              push, pop, mem_empty;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [AW:0]       occ, room;
  logic [DATA_W-1:0] mem_q;

  assign push = put && !full;
  assign room = DEPTH_C - occ;

  sfifo_ptr #(.AW(AW), .FLAG_REG(FLAG_REG)) u_ptr (
    .clk     (clk),
    .rst_n   (srst_n),
    .push    (push),
    .pop     (pop),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .occ     (occ),
    .full    (full),
    .empty   (mem_empty)
  );

  sfifo_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (push),
    .waddr (wr_addr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (mem_q)
  );

  sfifo_head #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_head (
    .clk       (clk),
    .rst_n     (srst_n),
    .mem_empty (mem_empty),
    .mem_data  (mem_q),
    .got       (got),
    .pop       (pop),
    .valid     (valid),
    .dout      (rdata)
  );

  sfifo_level #(.AW(AW), .BITS(RD_LVL_BITS)) u_fill (
    .cnt  (occ),
    .code (rd_fill)
  );

  sfifo_level #(.AW(AW), .BITS(WR_LVL_BITS)) u_room (
    .cnt  (room),
    .code (wr_room)
  );

endmodule

// File: rtl/sfifo_gv_chk.sv
module sfifo_gv_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned RB     = 0,
  parameter int unsigned WB     = 0,
  parameter int unsigned RLW    = 1,
  parameter int unsigned WLW    = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              put,
  input logic              got,
  input logic              full,
  input logic              valid,
  input logic [DATA_W-1:0] rdata,
  input logic [RLW-1:0]    rd_fill,
  input logic [WLW-1:0]    wr_room,
  input logic [AW:0]       occ
);

  localparam int DEPTH = 1 << AW;

  assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !got) |=> valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !got) |=> $stable(rdata));

  assert_full_has_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> valid);

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && put && !got) |=> full);

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_fill) * DEPTH) <= (int'(occ) << RB));

  assert_room_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_room) * DEPTH) <= ((DEPTH - int'(occ)) << WB));

endmodule

bind sfifo_gv sfifo_gv_chk #(
  .DATA_W (DATA_W),
  .AW     (AW),
  .RB     (RD_LVL_BITS),
  .WB     (WR_LVL_BITS),
  .RLW    (RLW),
  .WLW    (WLW)
) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .put     (put),
  .got     (got),
  .full    (full),
  .valid   (valid),
  .rdata   (rdata),
  .rd_fill (rd_fill),
  .wr_room (wr_room),
  .occ     (occ)
);

// File: tb/sfifo_gv_test.sv
`timescale 1ns/1ps
module sfifo_gv_test;

  localparam int CAP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       put = 1'b0;
  logic       got = 1'b0;
  logic [7:0] wdata = 8'h00;

  logic       full, valid;
  logic [7:0] rdata;
  logic [1:0] rd_fill, wr_room;

  logic       full_b, valid_b;
  logic [7:0] rdata_b;
  logic [0:0] fill_b, room_b;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  byte unsigned model[$];

  always #2.5 clk = ~clk;

  sfifo_gv #(.DATA_W(8), .DEPTH_MIN(5), .FLAG_REG(1'b1), .OUT_REG(1'b0),
             .RD_LVL_BITS(2), .WR_LVL_BITS(2)) uut (
    .clk(clk), .rst_n(rst_n), .put(put), .wdata(wdata), .full(full),
    .wr_room(wr_room), .got(got), .rdata(rdata), .valid(valid), .rd_fill(rd_fill));

  sfifo_gv #(.DATA_W(8), .DEPTH_MIN(5), .FLAG_REG(1'b0), .OUT_REG(1'b0),
             .RD_LVL_BITS(0), .WR_LVL_BITS(0)) uut_nolvl (
    .clk(clk), .rst_n(rst_n), .put(put), .wdata(wdata), .full(full_b),
    .wr_room(room_b), .got(got), .rdata(rdata_b), .valid(valid_b), .rd_fill(fill_b));

  function automatic int quant(int n);
    int v;
    v = (n * 4) / CAP;
    return (v > 3) ? 3 : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n;
    n = model.size();
    chk("R4 valid", int'(valid), int'(n > 0));
    if (n > 0) chk("R4 head word", int'(rdata), int'(model[0]));
    chk("R2 full", int'(full), int'(n == CAP));
    chk("R7 rd_fill", int'(rd_fill), quant(n));
    chk("R8 wr_room", int'(wr_room), quant(CAP - n));
    chk("R10 disabled fill", int'(fill_b), 0);
    chk("R10 disabled room", int'(room_b), 0);
  endtask

  // one cycle: drive after a falling edge, model the rising edge, compare at the next falling edge
  task automatic cyc(bit p, bit g, logic [7:0] d);
    int  n;
    bit  do_pop, do_push;
    put = p; got = g; wdata = d;
    @(posedge clk);
    n       = model.size();
    do_pop  = g && (n > 0);
    do_push = p && (n < CAP);
    if (do_pop)  void'(model.pop_front());
    if (do_push) model.push_back(byte'(d));
    @(negedge clk);
    put = 1'b0; got = 1'b0;
    compare_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values while reset is applied
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 rd_fill in reset", int'(rd_fill), 0);
    chk("R1 wr_room in reset", int'(wr_room), 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all();

    // R2 and R3: ten offers into eight slots
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'(i + 1));
    chk("R2 full after eight", int'(full), 1);
    chk("R3 head after overflow", int'(rdata), 1);
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 8'h00);
    chk("R3 dropped words absent", int'(valid), 0);

    // R5: consume requests on an empty buffer
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 8'h00);
    chk("R5 still empty", int'(valid), 0);
    chk("R5 fill unchanged", int'(rd_fill), 0);
    cyc(1'b1, 1'b0, 8'hA5);
    chk("R5 later word delivered", int'(rdata), 8'hA5);

    // R9: head held without got
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 8'h00);
      chk("R9 head held", int'(rdata), 8'hA5);
      chk("R9 valid held", int'(valid), 1);
    end

    // R6: balanced traffic at four stored words
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'(8'h30 + i));
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b1, 8'(8'h40 + i));
      chk("R6 fill steady", int'(rd_fill), 2);
      chk("R6 room steady", int'(wr_room), 2);
    end

    // mixed traffic at three biases
    for (int ph = 0; ph < 3; ph++) begin
      int pp, gp;
      pp = (ph == 0) ? 75 : (ph == 1) ? 30 : 50;
      gp = (ph == 0) ? 30 : (ph == 1) ? 75 : 50;
      for (int i = 0; i < 700; i++) begin
        cyc(($urandom_range(99) < pp), ($urandom_range(99) < gp), 8'($urandom_range(255)));
      end
    end

    while (model.size() > 0) cyc(1'b0, 1'b1, 8'h00);
    chk("R4 drained", int'(valid), 0);
    chk("R8 room at empty", int'(wr_room), 3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule